// File: doc/BRIEF.md
# Vectored Interrupt Controller with Atomic Enable Updates

This block gathers up to 32 interrupt request lines into one processor interrupt. Each line is fixed at build time as edge or level sensitive. Requests are held in a status register until software acknowledges them. A per-line enable mask picks which held requests count as pending. A vector register reports the lowest-numbered pending line, so a handler can read it, service that line, acknowledge it and read again until it sees all ones.

Software reaches the block over a single-cycle register bus. The bus has a byte address, a write strobe, write data and combinational read data. Enable bits can be replaced as a whole word. They can also be changed in place through a write-1-to-set port and a write-1-to-clear port, so no read-modify-write is needed. A two-bit master control gates the interrupt output.

The block has no state machine. All of its state is four register sets: the held requests, the input history used for edge detection, the enable mask and the two-bit master control. Each of them changes only on the bus writes and input events listed below.

Top module: `vic_core`

## Requirements
- R1: After reset, the status, enable and master-control registers read zero, the vector reads 0xFFFFFFFF and `irq_o` is low.
- R2: Byte offsets: 0x00 status, 0x04 pending, 0x08 enable, 0x0C acknowledge, 0x10 set-enable, 0x14 clear-enable, 0x18 vector, 0x1C master control. An offset is decoded only when address bits [1:0] are zero and all bits above bit 4 are zero.
- R3: An edge-kind line (its `EDGE_KIND` bit is 1) sets its status bit only on a low-to-high change. The bit stays set after the line falls. A line held high after an acknowledge does not set it again.
- R4: A level-kind line (its `EDGE_KIND` bit is 0) sets its status bit on every cycle it is high. A pulse stays held after the line falls. Acknowledging while the line is still high leaves the bit set.
- R5: Writing 1s to the acknowledge offset clears exactly those status bits, and 0xFFFFFFFF clears them all. If a line sets its bit in the same cycle as the acknowledge, the set wins.
- R6: A write to the enable offset replaces the whole mask. Set-enable ORs the written mask into the enables. Clear-enable clears only the written 1 bits.
- R7: The pending register reads status AND enable.
- R8: The vector reads the index of the lowest-numbered pending line, zero-extended, or 0xFFFFFFFF when nothing is pending.
- R9: The master register holds bit 0 (master enable) and bit 1 (output enable). `irq_o` is high exactly when both bits are 1 and any pending bit is 1.
- R10: Writes to status, pending and vector have no effect. Acknowledge, set-enable and clear-enable read back as zero.
- R11: Addresses that are not decoded read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | N_SRC | Interrupt request lines, synchronous to clk |
| bus_addr_i | input | ADDR_W | Byte address of the register access |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, combinational |
| irq_o | output | 1 | Interrupt toward the processor |

## Verification
A corrupted status bit shows up on the next read of the status, pending or vector offset. If the line is enabled and both master bits are set, it also shows on `irq_o` in the same cycle. A wrong enable bit changes pending, vector and `irq_o` in the cycle after the write that produced it. Because of this, every write in the bench is followed at once by a read of the affected offset and a check of `irq_o`. A stale edge-history flop shows only at a later edge, as a missed or doubled latch, so the bench holds edge lines high across an acknowledge to expose it.

// File: rtl/vic_pkg.sv
package vic_pkg;

    localparam int BUS_W = 32;

    // register selector taken from byte address bits [4:2]
    typedef enum logic [2:0] {
        SEL_STATUS  = 3'd0,
        SEL_PENDING = 3'd1,
        SEL_ENABLE  = 3'd2,
        SEL_ACK     = 3'd3,
        SEL_SETEN   = 3'd4,
        SEL_CLREN   = 3'd5,
        SEL_VECTOR  = 3'd6,
        SEL_MASTER  = 3'd7
    } vic_sel_e;

    localparam int MASTER_ON_BIT = 0;
    localparam int OUT_ON_BIT    = 1;

endpackage

// File: rtl/vic_source_latch.sv
module vic_source_latch #(
    parameter int           N         = 32,
    parameter logic [N-1:0] EDGE_KIND = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] src_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] status_o
);

    logic [N-1:0] src_q;
    logic [N-1:0] hit;
    logic [N-1:0] status_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) src_q <= '0;
        else        src_q <= src_i;
    end

    for (genvar i = 0; i < N; i++) begin : g_line
        if (EDGE_KIND[i]) begin : g_edge
            assign hit[i] = src_i[i] & ~src_q[i];

            // R3: a rising edge is always captured
            a_r3_edge_latch: assert property (@(posedge clk) disable iff (!rst_n)
                (src_i[i] && !src_q[i]) |=> status_q[i]);
            // R5: acknowledge without a new edge clears the bit
            a_r5_edge_ack: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_i[i] && !(src_i[i] && !src_q[i])) |=> !status_q[i]);
        end else begin : g_level
            assign hit[i] = src_i[i];

            // R4: a high level is held in status on the next cycle
            a_r4_level_latch: assert property (@(posedge clk) disable iff (!rst_n)
                src_i[i] |=> status_q[i]);
            // R5: acknowledge with the line low clears the bit
            a_r5_level_ack: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_i[i] && !src_i[i]) |=> !status_q[i]);
        end
    end

    // set has priority over a same-cycle acknowledge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q & ~clr_i) | hit;
    end

    assign status_o = status_q;

endmodule

// File: rtl/vic_enable_bank.sv
module vic_enable_bank #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_whole_i,
    input  logic         wr_set_i,
    input  logic         wr_clr_i,
    input  logic [N-1:0] mask_i,
    output logic [N-1:0] en_o
);

    logic [N-1:0] en_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          en_q <= '0;
        else if (wr_whole_i) en_q <= mask_i;
        else if (wr_set_i)   en_q <= en_q | mask_i;
        else if (wr_clr_i)   en_q <= en_q & ~mask_i;
    end

    assign en_o = en_q;

    // R6: set-enable turns the masked bits on and keeps the others
    a_r6_set_only_adds: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_set_i && !wr_whole_i) |=>
            (((en_q & $past(mask_i)) == $past(mask_i)) &&
             ((en_q & ~$past(mask_i)) == ($past(en_q) & ~$past(mask_i)))));

    // R6: clear-enable turns the masked bits off and keeps the others
    a_r6_clr_only_removes: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_clr_i && !wr_whole_i && !wr_set_i) |=>
            (((en_q & $past(mask_i)) == '0) &&
             ((en_q & ~$past(mask_i)) == ($past(en_q) & ~$past(mask_i)))));

endmodule

// File: rtl/vic_lowest_first.sv
module vic_lowest_first #(
    parameter int N     = 32,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req_i,
    output logic             found_o,
    output logic [IDX_W-1:0] idx_o
);

    // scan from the top so the lowest set bit is the last assignment
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                found_o = 1'b1;
                idx_o   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/vic_core.sv
module vic_core
    import vic_pkg::*;
#(
    parameter int                 N_SRC     = 32,          // at most 32
    parameter logic [N_SRC-1:0]   EDGE_KIND = N_SRC'(32'h0000_00FF),
    parameter int                 ADDR_W    = 8            // at least 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  src_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_wr_i,
    input  logic [BUS_W-1:0]  bus_wdata_i,
    output logic [BUS_W-1:0]  bus_rdata_o,
    output logic              irq_o
);

    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

    // ---- address decode ----
    logic     addr_ok;
    logic     wr_hit;
    vic_sel_e sel;

    assign addr_ok = (bus_addr_i[1:0] == 2'b00) && ((bus_addr_i >> 5) == '0);
    assign sel     = vic_sel_e'(bus_addr_i[4:2]);
    assign wr_hit  = bus_wr_i && addr_ok;

    logic [N_SRC-1:0] wmask;
    logic [N_SRC-1:0] ack_mask;

    assign wmask    = bus_wdata_i[N_SRC-1:0];
    assign ack_mask = (wr_hit && sel == SEL_ACK) ? wmask : '0;

    // ---- request capture ----
    logic [N_SRC-1:0] status;

    vic_source_latch #(
        .N         (N_SRC),
        .EDGE_KIND (EDGE_KIND)
    ) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_i    (src_i),
        .clr_i    (ack_mask),
        .status_o (status)
    );

    // ---- enable mask ----
    logic [N_SRC-1:0] en;

    vic_enable_bank #(
        .N (N_SRC)
    ) u_enable (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_whole_i (wr_hit && sel == SEL_ENABLE),
        .wr_set_i   (wr_hit && sel == SEL_SETEN),
        .wr_clr_i   (wr_hit && sel == SEL_CLREN),
        .mask_i     (wmask),
        .en_o       (en)
    );

    // ---- master control ----
    logic [1:0] master_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            master_q <= 2'b00;
        else if (wr_hit && sel == SEL_MASTER)  master_q <= bus_wdata_i[1:0];
    end

    // ---- pending, vector, output ----
    logic [N_SRC-1:0] pending;
    logic             vec_found;
    logic [IDX_W-1:0] vec_idx;
    logic [BUS_W-1:0] vec_word;

    assign pending = status & en;

    vic_lowest_first #(
        .N     (N_SRC),
        .IDX_W (IDX_W)
    ) u_prio (
        .req_i   (pending),
        .found_o (vec_found),
        .idx_o   (vec_idx)
    );

    assign vec_word = vec_found ? BUS_W'(vec_idx) : '1;
    assign irq_o    = master_q[MASTER_ON_BIT] && master_q[OUT_ON_BIT] && (|pending);

    // ---- read mux ----
    logic [BUS_W-1:0] status_w, pending_w, en_w;

    always_comb begin
        status_w  = '0;
        pending_w = '0;
        en_w      = '0;
        status_w[N_SRC-1:0]  = status;
        pending_w[N_SRC-1:0] = pending;
        en_w[N_SRC-1:0]      = en;
    end

    always_comb begin
        bus_rdata_o = '0;
        if (addr_ok) begin
            unique case (sel)
                SEL_STATUS:  bus_rdata_o = status_w;
                SEL_PENDING: bus_rdata_o = pending_w;
                SEL_ENABLE:  bus_rdata_o = en_w;
                SEL_ACK:     bus_rdata_o = '0;
                SEL_SETEN:   bus_rdata_o = '0;
                SEL_CLREN:   bus_rdata_o = '0;
                SEL_VECTOR:  bus_rdata_o = vec_word;
                SEL_MASTER:  bus_rdata_o = {{(BUS_W-2){1'b0}}, master_q};
            endcase
        end
    end

    // ---- assertions ----
    // R9: the output never rises unless both master bits are set
    a_r9_irq_needs_master: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (master_q == 2'b11));

    // R8: the encoder only ever names a line that is pending
    a_r8_vector_is_pending: assert property (@(posedge clk) disable iff (!rst_n)
        vec_found |-> pending[vec_idx]);

    // R8: with nothing pending the encoder reports no hit
    a_r8_empty_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (pending == '0) |-> !vec_found);

    // R11: undecoded writes leave enables and master control untouched
    a_r11_stray_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && !addr_ok) |=> (en == $past(en) && master_q == $past(master_q)));

endmodule

// File: tb/vic_core_tb_top.sv
module vic_core_tb_top;

    localparam int CLK_PERIOD = 10;

    localparam logic [7:0] A_ST  = 8'h00;
    localparam logic [7:0] A_PND = 8'h04;
    localparam logic [7:0] A_EN  = 8'h08;
    localparam logic [7:0] A_ACK = 8'h0C;
    localparam logic [7:0] A_SEN = 8'h10;
    localparam logic [7:0] A_CEN = 8'h14;
    localparam logic [7:0] A_VEC = 8'h18;
    localparam logic [7:0] A_MER = 8'h1C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src = '0;
    logic [7:0]  addr = '0;
    logic        wr = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // scoreboard queues
    logic [31:0] q_data[$];
    logic        q_irq[$];
    string       q_tag[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    vic_core #(
        .N_SRC     (32),
        .EDGE_KIND (32'h0000_00FF),
        .ADDR_W    (8)
    ) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_i       (src),
        .bus_addr_i  (addr),
        .bus_wr_i    (wr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .irq_o       (irq)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    // driver: present a read and push the expected result
    task automatic expect_rd(input logic [7:0] a, input logic [31:0] d,
                             input logic exp_irq, input string tag);
        addr = a;
        q_data.push_back(d);
        q_irq.push_back(exp_irq);
        q_tag.push_back(tag);
        @(negedge clk);
    endtask

    // monitor: compare one item shortly after each falling edge
    initial begin
        logic [31:0] ed;
        logic        ei;
        string       et;
        forever begin
            @(negedge clk);
            #1;
            if (q_data.size() > 0) begin
                ed = q_data.pop_front();
                ei = q_irq.pop_front();
                et = q_tag.pop_front();
                n_checks++;
                if (rdata !== ed || irq !== ei) begin
                    n_fail++;
                    $display("FAIL %s: got data=%h irq=%b, expected data=%h irq=%b",
                             et, rdata, irq, ed, ei);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got running, expected finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();

        // R1 reset state
        expect_rd(A_ST,  32'h0, 1'b0, "R1 status zero");
        expect_rd(A_EN,  32'h0, 1'b0, "R1 enable zero");
        expect_rd(A_MER, 32'h0, 1'b0, "R1 master zero");
        expect_rd(A_VEC, 32'hFFFF_FFFF, 1'b0, "R1 vector empty");

        // R3 edge capture and hold
        src[3] = 1'b1; step(); src[3] = 1'b0;
        expect_rd(A_ST, 32'h0000_0008, 1'b0, "R3 edge latched after fall");
        src[5] = 1'b1; step();
        expect_rd(A_ST, 32'h0000_0028, 1'b0, "R3 second edge latched");
        bus_write(A_ACK, 32'h20);
        expect_rd(A_ST, 32'h0000_0008, 1'b0, "R3 held-high edge line not relatched");
        src[5] = 1'b0;

        // R4 level capture
        src[9] = 1'b1; step();
        expect_rd(A_ST, 32'h0000_0208, 1'b0, "R4 level latched");
        bus_write(A_ACK, 32'h200);
        expect_rd(A_ST, 32'h0000_0208, 1'b0, "R4 ack while high keeps bit");
        src[9] = 1'b0; step();
        expect_rd(A_ST, 32'h0000_0208, 1'b0, "R4 pulse held after fall");
        bus_write(A_ACK, 32'h200);
        expect_rd(A_ST, 32'h0000_0008, 1'b0, "R5 ack clears only bit 9");

        // R7 / R9 pending and master gating
        bus_write(A_EN, 32'h8);
        expect_rd(A_PND, 32'h8, 1'b0, "R7 pending with master off");
        bus_write(A_MER, 32'h1);
        expect_rd(A_MER, 32'h1, 1'b0, "R9 one master bit keeps irq low");
        bus_write(A_MER, 32'h3);
        expect_rd(A_MER, 32'h3, 1'b1, "R9 both master bits raise irq");
        expect_rd(A_VEC, 32'h3, 1'b1, "R8 single pending index");

        // R6 / R8 atomic enable updates and priority
        src[12] = 1'b1; step(); src[12] = 1'b0; step();
        bus_write(A_SEN, 32'h1000);
        expect_rd(A_EN,  32'h1008, 1'b1, "R6 set-enable keeps bit 3");
        expect_rd(A_VEC, 32'h3, 1'b1, "R8 lowest of 3 and 12");
        bus_write(A_CEN, 32'h8);
        expect_rd(A_EN,  32'h1000, 1'b1, "R6 clear-enable removes only bit 3");
        expect_rd(A_VEC, 32'hC, 1'b1, "R8 vector moves to 12");
        expect_rd(A_PND, 32'h1000, 1'b1, "R7 pending is status and enable");

        // R10 read-only and write-only registers
        bus_write(A_ST, 32'hFFFF_FFFF);
        expect_rd(A_ST, 32'h1008, 1'b1, "R10 status write ignored");
        bus_write(A_PND, 32'h0);
        expect_rd(A_PND, 32'h1000, 1'b1, "R10 pending write ignored");
        bus_write(A_VEC, 32'h0);
        expect_rd(A_VEC, 32'hC, 1'b1, "R10 vector write ignored");
        expect_rd(A_SEN, 32'h0, 1'b1, "R10 set-enable reads zero");
        expect_rd(A_CEN, 32'h0, 1'b1, "R10 clear-enable reads zero");
        expect_rd(A_ACK, 32'h0, 1'b1, "R10 acknowledge reads zero");

        // R11 / R2 undecoded addresses
        bus_write(8'h28, 32'hFFFF_FFFF);
        expect_rd(A_EN, 32'h1000, 1'b1, "R11 aliasing write ignored");
        expect_rd(8'h28, 32'h0, 1'b1, "R11 high address reads zero");
        expect_rd(8'h09, 32'h0, 1'b1, "R2 unaligned address reads zero");

        // R5 acknowledge everything
        bus_write(A_ACK, 32'hFFFF_FFFF);
        expect_rd(A_ST,  32'h0, 1'b0, "R5 ack all clears status");
        expect_rd(A_VEC, 32'hFFFF_FFFF, 1'b0, "R8 vector empty after ack");

        // R6 whole-word writes
        bus_write(A_EN, 32'hFFFF_FFFF);
        expect_rd(A_EN, 32'hFFFF_FFFF, 1'b0, "R6 whole write all ones");
        bus_write(A_EN, 32'h0);
        expect_rd(A_EN, 32'h0, 1'b0, "R6 whole write zero");

        // R9 gating with a pending line 0
        bus_write(A_EN, 32'h1);
        src[0] = 1'b1; step(); src[0] = 1'b0;
        expect_rd(A_PND, 32'h1, 1'b1, "R7 line 0 pending");
        expect_rd(A_VEC, 32'h0, 1'b1, "R8 index zero");
        bus_write(A_MER, 32'h2);
        expect_rd(A_MER, 32'h2, 1'b0, "R9 master bit 0 off gates irq");
        bus_write(A_MER, 32'h3);
        expect_rd(A_PND, 32'h1, 1'b1, "R9 irq returns");

        // R5 set wins over same-cycle acknowledge
        @(negedge clk);
        wr = 1'b1; addr = A_ACK; wdata = 32'h2; src[1] = 1'b1;
        @(negedge clk);
        wr = 1'b0; src[1] = 1'b0;
        expect_rd(A_ST, 32'h3, 1'b1, "R5 edge beats same-cycle ack");
        bus_write(A_ACK, 32'h1);
        expect_rd(A_ST, 32'h2, 1'b0, "R5 ack clears only bit 0");

        step(); step();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule